// File: doc/BRIEF.md
# Shared-Buffer Output-Queued Multicast Switch Core

A four-in, four-out packet switch core. Each packet is written once into a common pool of fixed-size cells, and the cells of a packet are chained by a next-cell pointer. When a packet's head cell arrives, a descriptor holding a pointer to the head is appended to the descriptor queue of every egress port named in the packet's destination mask. There is no ingress queueing stage and no central arbiter. All four ingress ports may write cells and push descriptors in the same cycle.

Each egress port works through its own descriptor queue. It follows the cell chain and sends one cell per cycle while its `tx_ready` is high. It can start a packet before the tail of that packet has arrived. A multicast packet is read separately by each of its destination ports. Each stored cell carries a reader count, and the cell goes back to the free pool when its last reader moves past it. If the pool cannot hold a whole packet, the packet is refused at its head cell and a per-port drop counter records the loss.

Top module: `shared_buf_switch`

## Requirements
- R1: An idle ingress port treats its next valid cycle as a packet head. On that cycle `in_len` holds the cell count minus one (0 to 31) and bit e of `in_mask` selects egress e. Each following valid cycle of that port carries the next cell, until the stated count has been delivered.
- R2: Every accepted packet is delivered on each egress port in its mask. Each cell is delivered exactly once per port, with its data unchanged and in its original order.
- R3: An egress port sends all cells of one packet on consecutive transmit opportunities, with no cell of another packet in between. `out_last` is high exactly on the final cell and never without `out_valid`.
- R4: Packets bound for the same egress leave in the order their heads were accepted. Heads accepted in the same cycle leave in ascending ingress index.
- R5: `out_valid[e]` can be high only in the cycle after a cycle in which `tx_ready[e]` was high.
- R6: Cut-through: an egress may send the first cells of a packet before the last cell of that packet has been supplied. It never reads a cell that has not been written.
- R7: A head is accepted only if its cell count fits in the free cells minus the cells still owed to unfinished accepted packets. Otherwise the whole packet is discarded, its later cells are ignored, and the port's 16-bit field `drop_cnt[16i+15:16i]` goes up by one in the cycle after the head.
- R8: Heads that arrive in the same cycle are judged in ascending ingress index. Each head sees only the space left by the lower-indexed heads, and every cell written in that cycle gets a distinct slot.
- R9: A head with an all-zero mask is discarded and counted as a drop.
- R10: A cell is held once, whatever its fan-out, and returns to the pool once all of its destination ports have read past it. After all traffic drains, all 256 cells can be used again.
- R11: After reset, `out_valid`, `out_last` and every drop counter are zero, and all cells are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 4 | Per-ingress cell valid |
| in_len | input | 20 | Per-ingress cell count minus one, 5 bits each, sampled on heads |
| in_mask | input | 16 | Per-ingress destination mask, 4 bits each, sampled on heads |
| in_data | input | 2048 | Per-ingress 64-byte cell payload |
| tx_ready | input | 4 | Per-egress transmit permission |
| out_valid | output | 4 | Per-egress cell valid |
| out_last | output | 4 | Per-egress final-cell flag |
| out_data | output | 2048 | Per-egress 64-byte cell payload |
| drop_cnt | output | 64 | Per-ingress 16-bit dropped-packet counters |

## Verification
The first pattern is unicast traffic with one destination per source. It shows that basic delivery and the last-cell flag are correct. The second pattern sends heads from all four sources to one egress in the same cycle, which separates correct index ordering from ordering that is merely fair or arbitrary. Mixed multicast and zero-mask heads show replication, per-cell read counting and whole-packet discard. A 32-cell packet is used to confirm that output begins before input ends. Random egress pausing tests that transmission stops and resumes without interleaving. Two fills done with all egress ports paused then tell apart exact admission arithmetic within one cycle, and a pool that has fully recovered its cells after multicast reads.

// File: rtl/shared_buf_switch.sv
module shared_buf_switch #(
  parameter int NP     = 4,
  parameter int CELLS  = 256,
  parameter int MAXC   = 32,
  parameter int CELL_W = 512,
  parameter int DW     = 16
)(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NP-1:0]               in_valid,
  input  logic [NP*$clog2(MAXC)-1:0]  in_len,
  input  logic [NP*NP-1:0]            in_mask,
  input  logic [NP*CELL_W-1:0]        in_data,
  input  logic [NP-1:0]               tx_ready,
  output logic [NP-1:0]               out_valid,
  output logic [NP-1:0]               out_last,
  output logic [NP*CELL_W-1:0]        out_data,
  output logic [NP*DW-1:0]            drop_cnt
);
  localparam int AW = $clog2(CELLS);
  localparam int LW = $clog2(MAXC);
  localparam int CW = $clog2(NP+1);
  localparam int SW = AW + 2;
  localparam int QW = AW + LW;

  logic [CELL_W-1:0] mem  [CELLS];
  logic [AW-1:0]     link [CELLS];
  logic [CW-1:0]     refc [CELLS];
  logic [CW-1:0]     dec  [CELLS];
  logic [CELLS-1:0]  free_map, written, linked, alloc_bits, link_set, freed;
  logic [SW-1:0]     nfree, rsv;

  logic [LW:0]   rem [NP];
  logic [LW:0]   plen [NP];
  logic [AW-1:0] tail [NP];
  logic [AW-1:0] idx [NP];
  logic [CW-1:0] pcnt [NP];
  logic [NP-1:0] keep, sop, acc, take;

  logic [QW-1:0] qmem [NP][CELLS];
  logic [AW:0]   wp [NP];
  logic [AW:0]   rp [NP];
  logic [CW-1:0] qoff [NP][NP];
  logic [CW-1:0] qcnt [NP];

  logic [NP-1:0] busy, first, load, fire, lastc;
  logic [AW-1:0] ptr [NP];
  logic [AW-1:0] rd [NP];
  logic [LW:0]   erem [NP];

  assign nfree = SW'($countones(free_map));

  always_comb begin
    rsv = '0;
    for (int i = 0; i < NP; i++)
      if (keep[i]) rsv = rsv + SW'(rem[i]);
  end

  // admission and slot allocation, lowest ingress index first
  always_comb begin
    logic [SW-1:0]    avail;
    logic [CELLS-1:0] m;
    avail = nfree - rsv;
    m = free_map;
    alloc_bits = '0;
    link_set = '0;
    for (int i = 0; i < NP; i++) begin
      sop[i]  = in_valid[i] && (rem[i] == '0);
      plen[i] = (LW+1)'(in_len[i*LW +: LW]) + 1'b1;
      acc[i]  = sop[i] && (|in_mask[i*NP +: NP]) && (SW'(plen[i]) <= avail);
      if (acc[i]) avail = avail - SW'(plen[i]);
      take[i] = in_valid[i] && (sop[i] ? acc[i] : keep[i]);
      idx[i] = '0;
      if (take[i]) begin
        for (int c = CELLS-1; c >= 0; c--)
          if (m[c]) idx[i] = AW'(c);
        m[idx[i]] = 1'b0;
        alloc_bits[idx[i]] = 1'b1;
        if (!sop[i]) link_set[tail[i]] = 1'b1;
      end
    end
  end

  always_comb begin
    logic [CW-1:0] cnt;
    for (int e = 0; e < NP; e++) begin
      cnt = '0;
      for (int i = 0; i < NP; i++) begin
        qoff[e][i] = cnt;
        if (acc[i] && in_mask[i*NP + e]) cnt = cnt + 1'b1;
      end
      qcnt[e] = cnt;
    end
  end

  always_comb begin
    for (int e = 0; e < NP; e++) begin
      rd[e]    = first[e] ? ptr[e] : link[ptr[e]];
      fire[e]  = busy[e] && tx_ready[e] && (first[e] ? written[ptr[e]] : linked[ptr[e]]);
      lastc[e] = (erem[e] == (LW+1)'(1));
      load[e]  = !busy[e] && (wp[e] != rp[e]);
    end
  end

  // a reader releases a cell when it moves past it or ends on it
  always_comb begin
    for (int c = 0; c < CELLS; c++) dec[c] = '0;
    for (int e = 0; e < NP; e++) begin
      if (fire[e] && !first[e]) dec[ptr[e]] = dec[ptr[e]] + 1'b1;
      if (fire[e] && lastc[e])  dec[rd[e]]  = dec[rd[e]] + 1'b1;
    end
    for (int c = 0; c < CELLS; c++) freed[c] = (dec[c] != '0) && (dec[c] == refc[c]);
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < CELLS; c++)
      if (dec[c] != '0) refc[c] <= refc[c] - dec[c];
    for (int i = 0; i < NP; i++)
      if (take[i]) begin
        mem[idx[i]]  <= in_data[i*CELL_W +: CELL_W];
        refc[idx[i]] <= sop[i] ? CW'($countones(in_mask[i*NP +: NP])) : pcnt[i];
        if (!sop[i]) link[tail[i]] <= idx[i];
      end
    for (int e = 0; e < NP; e++) begin
      for (int i = 0; i < NP; i++)
        if (acc[i] && in_mask[i*NP + e])
          qmem[e][wp[e][AW-1:0] + AW'(qoff[e][i])] <= {idx[i], in_len[i*LW +: LW]};
      if (fire[e]) out_data[e*CELL_W +: CELL_W] <= mem[rd[e]];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_map <= '1;
      written <= '0;
      linked <= '0;
      keep <= '0;
      busy <= '0;
      first <= '0;
      out_valid <= '0;
      out_last <= '0;
      drop_cnt <= '0;
      for (int i = 0; i < NP; i++) begin
        rem[i] <= '0; tail[i] <= '0; pcnt[i] <= '0;
        wp[i] <= '0; rp[i] <= '0; ptr[i] <= '0; erem[i] <= '0;
      end
    end else begin
      free_map <= (free_map & ~alloc_bits) | freed;
      written  <= (written | alloc_bits) & ~freed;
      linked   <= (linked | link_set) & ~freed;
      for (int i = 0; i < NP; i++) begin
        if (take[i]) tail[i] <= idx[i];
        if (sop[i]) begin
          rem[i]  <= plen[i] - 1'b1;
          keep[i] <= acc[i];
          pcnt[i] <= CW'($countones(in_mask[i*NP +: NP]));
          if (!acc[i]) drop_cnt[i*DW +: DW] <= drop_cnt[i*DW +: DW] + 1'b1;
        end else if (in_valid[i]) begin
          rem[i] <= rem[i] - 1'b1;
        end
      end
      for (int e = 0; e < NP; e++) begin
        wp[e] <= wp[e] + (AW+1)'(qcnt[e]);
        out_valid[e] <= fire[e];
        out_last[e]  <= fire[e] && lastc[e];
        if (load[e]) begin
          busy[e]  <= 1'b1;
          first[e] <= 1'b1;
          ptr[e]   <= qmem[e][rp[e][AW-1:0]][QW-1:LW];
          erem[e]  <= (LW+1)'(qmem[e][rp[e][AW-1:0]][LW-1:0]) + 1'b1;
          rp[e]    <= rp[e] + 1'b1;
        end else if (fire[e]) begin
          ptr[e]   <= rd[e];
          first[e] <= 1'b0;
          erem[e]  <= erem[e] - 1'b1;
          if (lastc[e]) busy[e] <= 1'b0;
        end
      end
    end
  end

  p_rsv_fits_r7: assert property (@(posedge clk) disable iff (!rst_n) rsv <= nfree);

  for (genvar i = 0; i < NP; i++) begin : g_in_chk
    p_alloc_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
      take[i] |-> free_map[idx[i]]);
    p_drop_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_cnt[i*DW +: DW] != $past(drop_cnt[i*DW +: DW])) |->
      (drop_cnt[i*DW +: DW] == $past(drop_cnt[i*DW +: DW]) + 1'b1));
    for (genvar j = i + 1; j < NP; j++) begin : g_pair
      p_distinct_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (take[i] && take[j]) |-> (idx[i] != idx[j]));
    end
  end

  for (genvar e = 0; e < NP; e++) begin : g_out_chk
    p_tx_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[e] |-> $past(tx_ready[e]));
    p_last_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_last[e] |-> out_valid[e]);
    p_read_written_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fire[e] |-> written[rd[e]]);
  end
endmodule

// File: tb/shared_buf_switch_test.sv
module shared_buf_switch_test;
  localparam int PERIOD = 10;
  localparam int NP = 4;
  localparam int CELLS = 256;
  localparam int MAXC = 32;
  localparam int CELL_W = 512;
  localparam int DW = 16;
  localparam int LW = 5;
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] in_valid = '0;
  logic [NP*LW-1:0] in_len = '0;
  logic [NP*NP-1:0] in_mask = '0;
  logic [NP*CELL_W-1:0] in_data = '0;
  logic [NP-1:0] tx_ready = '0;
  logic [NP-1:0] out_valid, out_last;
  logic [NP*CELL_W-1:0] out_data;
  logic [NP*DW-1:0] drop_cnt;

  shared_buf_switch #(.NP(NP), .CELLS(CELLS), .MAXC(MAXC), .CELL_W(CELL_W), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_len(in_len), .in_mask(in_mask),
    .in_data(in_data), .tx_ready(tx_ready), .out_valid(out_valid), .out_last(out_last),
    .out_data(out_data), .drop_cnt(drop_cnt));

  typedef struct { bit v; bit sop; int len; logic [NP-1:0] mask; int pid; int idx; } item_t;
  typedef struct { logic [CELL_W-1:0] d; bit last; } exp_t;

  item_t drvq [NP][$];
  exp_t  expq [NP][$];
  int checks = 0, fails = 0, cyc = 0, budget = 1 << 30;
  int exp_drop [NP];
  bit rnd_tx = 1'b0, done = 1'b0;
  logic [NP-1:0] tx_want = '1, tx_applied = '0;
  int ct_first_out = -1, ct_last_in = -1;

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [CELL_W-1:0] mkd(int p, int k, int c);
    logic [31:0] w;
    w = {8'(p), 8'(k), 8'(c), 8'h5A};
    return {(CELL_W/32){w}};
  endfunction

  task automatic send(int p, int len, logic [NP-1:0] mask, int pid);
    for (int c = 0; c < len; c++) drvq[p].push_back('{1'b1, c == 0, len, mask, pid, c});
  endtask

  task automatic gap(int p, int n);
    for (int c = 0; c < n; c++) drvq[p].push_back('{1'b0, 1'b0, 0, '0, 0, -1});
  endtask

  function automatic bit pending();
    for (int p = 0; p < NP; p++)
      if (drvq[p].size() != 0 || expq[p].size() != 0) return 1'b1;
    return 1'b0;
  endfunction

  task automatic drain();
    while (pending()) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic inputs_done();
    bit busyq;
    busyq = 1'b1;
    while (busyq) begin
      busyq = 1'b0;
      for (int p = 0; p < NP; p++) if (drvq[p].size() != 0) busyq = 1'b1;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  // reference model and per-clock comparison
  always @(negedge clk) begin
    exp_t x;
    item_t it;
    cyc++;
    if (rst_n) begin
      for (int e = 0; e < NP; e++) begin
        if (out_valid[e]) begin
          checks++;
          if (!tx_applied[e]) begin
            fails++;
            $display("FAIL R5 egress %0d out_valid=1 after tx_ready=0, expected 0", e);
          end
          checks++;
          if (expq[e].size() == 0) begin
            fails++;
            $display("FAIL R2 egress %0d unexpected cell %h, expected none", e, out_data[e*CELL_W +: 32]);
          end else begin
            x = expq[e].pop_front();
            if (out_data[e*CELL_W +: CELL_W] !== x.d) begin
              fails++;
              $display("FAIL R2 R4 egress %0d data %h, expected %h", e, out_data[e*CELL_W +: 32], x.d[31:0]);
            end else if (out_last[e] !== x.last) begin
              fails++;
              $display("FAIL R3 egress %0d last %b, expected %b", e, out_last[e], x.last);
            end
            if (e == 3 && x.d == mkd(0, 30, 0)) ct_first_out = cyc;
          end
        end else if (out_last[e]) begin
          checks++; fails++;
          $display("FAIL R3 egress %0d out_last=1 without valid, expected 0", e);
        end
      end
      for (int p = 0; p < NP; p++) begin
        checks++;
        if (drop_cnt[p*DW +: DW] !== DW'(exp_drop[p])) begin
          fails++;
          $display("FAIL R7 R9 port %0d drop_cnt %0d, expected %0d", p, drop_cnt[p*DW +: DW], exp_drop[p]);
        end
      end
    end
    tx_ready = rnd_tx ? NP'($urandom) : tx_want;
    tx_applied = tx_ready;
    for (int p = 0; p < NP; p++) begin
      in_valid[p] = 1'b0;
      if (drvq[p].size() != 0) begin
        it = drvq[p].pop_front();
        if (it.v) begin
          in_valid[p] = 1'b1;
          in_data[p*CELL_W +: CELL_W] = mkd(p, it.pid, it.idx);
          if (p == 0 && it.pid == 30 && it.idx == 31) ct_last_in = cyc;
          if (it.sop) begin
            in_len[p*LW +: LW] = LW'(it.len - 1);
            in_mask[p*NP +: NP] = it.mask;
            if (it.mask != '0 && it.len <= budget) begin
              budget -= it.len;
              for (int e = 0; e < NP; e++)
                if (it.mask[e])
                  for (int c = 0; c < it.len; c++)
                    expq[e].push_back('{mkd(p, it.pid, c), c == it.len - 1});
            end else begin
              exp_drop[p]++;
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog expired with traffic pending, expected drained");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < NP; p++) exp_drop[p] = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== '0 || out_last !== '0 || drop_cnt !== '0) begin
      fails++;
      $display("FAIL R11 reset outputs valid=%b last=%b drops=%h, expected 0", out_valid, out_last, drop_cnt);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== '0 || drop_cnt !== '0) begin
      fails++;
      $display("FAIL R11 after reset valid=%b drops=%h, expected 0", out_valid, drop_cnt);
    end

    // R1 R2 R3: unicast
    send(0, 3, 4'b0010, 1); send(1, 1, 4'b0100, 1); send(2, 7, 4'b1000, 1); send(3, 2, 4'b0001, 1);
    send(0, 1, 4'b0001, 2); send(1, 4, 4'b1000, 2); send(2, 2, 4'b0010, 2); send(3, 5, 4'b0100, 2);
    drain();

    // R4: all heads to one egress in the same cycle
    for (int p = 0; p < NP; p++) begin send(p, 2 + p, 4'b0100, 10); send(p, 1, 4'b0100, 11); end
    drain();

    // R2 R10: multicast; R9: zero mask with trailing cells ignored
    send(1, 5, 4'b1111, 20); send(3, 3, 4'b0101, 20); send(0, 4, 4'b1000, 20); send(2, 2, 4'b0011, 20);
    send(2, 3, 4'b0000, 21); send(2, 1, 4'b0010, 22);
    drain();

    // R6: cut-through on a 32-cell packet
    send(0, 32, 4'b1000, 30);
    drain();
    checks++;
    if (!(ct_first_out >= 0 && ct_first_out < ct_last_in)) begin
      fails++;
      $display("FAIL R6 first output at cycle %0d, expected before last input at %0d", ct_first_out, ct_last_in);
    end

    // R3 R5: random egress pauses with mixed traffic
    rnd_tx = 1'b1;
    for (int p = 0; p < NP; p++)
      for (int k = 0; k < 3; k++) send(p, 1 + ($urandom % 8), NP'($urandom % 16), 40 + k);
    drain();
    rnd_tx = 1'b0;

    // R7 R8: paused fill, admission order within one cycle
    tx_want = '0;
    budget = CELLS;
    for (int p = 0; p < NP; p++) send(p, 32, NP'(1 << p), 50);
    for (int p = 0; p < 3; p++) send(p, 32, NP'(1 << p), 51);
    send(3, 8, 4'b1000, 51); gap(3, 24);
    send(0, 16, 4'b0001, 52); send(1, 16, 4'b0010, 52); send(2, 8, 4'b0100, 52); send(3, 1, 4'b1000, 52);
    inputs_done();
    checks++;
    if (drop_cnt[1*DW +: DW] !== DW'(exp_drop[1]) || drop_cnt[3*DW +: DW] !== DW'(exp_drop[3])) begin
      fails++;
      $display("FAIL R8 drops p1=%0d p3=%0d, expected %0d %0d", drop_cnt[1*DW +: DW], drop_cnt[3*DW +: DW], exp_drop[1], exp_drop[3]);
    end
    tx_want = '1;
    drain();
    budget = 1 << 30;

    // R10: full pool usable again after multicast drain
    tx_want = '0;
    budget = CELLS;
    for (int p = 0; p < NP; p++) begin send(p, 32, 4'b1111, 60); send(p, 32, 4'b1111, 61); end
    send(0, 1, 4'b0001, 62);
    inputs_done();
    checks++;
    if (drop_cnt[0*DW +: DW] !== DW'(exp_drop[0])) begin
      fails++;
      $display("FAIL R10 port 0 drops %0d, expected %0d", drop_cnt[0*DW +: DW], exp_drop[0]);
    end
    tx_want = '1;
    drain();
    budget = 1 << 30;

    checks++;
    if (pending()) begin
      fails++;
      $display("FAIL R2 cells still expected at end, expected none");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule